// File: doc/BRIEF.md
# Multi-Lane Serial Result Shifter

This block is the serial readout engine of a six-channel converter. The six channels are grouped into three pairs: A, B and C. The block runs on the serial clock. A falling edge on the active-low frame-sync input starts a frame. At that edge the six 16-bit results and the lane configuration are captured. The results are then shifted out MSB first on up to three data lanes, one bit per serial-clock cycle.

Two lane-select inputs decide how the channel pairs are spread across the lanes. Lane A is always in use. When lane B or lane C is switched off, the channels it would carry fold onto the remaining lanes, and the switched-off lane stays at zero.

A chain enable lets several devices share the lanes. Each active lane takes the serial output of an upstream device on its chain input. After its own data, the lane replays one local frame's worth of those upstream bits.

Top module: `lane_result_shifter`

## Requirements
- R1: A frame starts at a rising clock edge where frameSyncN is sampled low and was sampled high at the previous edge. Bit 0 of every active lane appears on sdo right after that edge, and bit k appears after the k-th following edge. After reset, no frame starts until frameSyncN has been seen high.
- R2: At the start edge, channel n is captured from resultIn[16n+15:16n], with n = 0 for A0, 1 for A1, 2 for B0, 3 for B1, 4 for C0 and 5 for C1. Each channel occupies 16 bit periods, MSB first. Lane A, B and C drive sdo[0], sdo[1] and sdo[2].
- R3: With selB=1 and selC=1, lane A sends A0 A1, lane B sends B0 B1, and lane C sends C0 C1.
- R4: With selB=1 and selC=0, lane A sends A0 A1 C0, lane B sends B0 B1 C1, and lane C stays at 0.
- R5: With selB=0 and selC=0, lane A sends A0 A1 B0 B1 C0 C1, and lanes B and C stay at 0.
- R6: With selB=0 and selC=1, lane A sends A0 A1 B0 B1, lane C sends C0 C1, and lane B stays at 0.
- R7: With chainEn=1 at the start edge, each active lane with L local bits sends L more bits after them. Bit L+j-1 is the value of chainIn[lane] sampled at the j-th edge after the start edge. The chain inputs of lanes that are switched off are ignored.
- R8: A lane drives 0 after its last local or chained bit until the next frame. All lanes drive 0 during and after reset and while no frame is running.
- R9: A new frameSyncN falling edge in the middle of a frame restarts the transfer from bit 0, with freshly captured results, selects and chain enable.
- R10: Changes on selB, selC, chainEn and resultIn after the start edge have no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; new bits are launched on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| frameSyncN | input | 1 | Frame sync; a falling edge starts or restarts a frame |
| selB | input | 1 | Enables lane B |
| selC | input | 1 | Enables lane C |
| chainEn | input | 1 | Appends upstream data after the local data |
| chainIn | input | 3 | Upstream serial data per lane (bit 0 = lane A) |
| resultIn | input | 96 | Six 16-bit channel results, captured at frame start |
| sdo | output | 3 | Serial data lanes (bit 0 = lane A) |

## Verification
The bench sweeps all four lane-select combinations, with the chain off and on. A wrong folding order would show up as a misplaced C0, C1 or B-pair word on lane A or B. An enabled-but-idle lane would show up as a lane that should stay silent carrying bits.

Upstream bits arrive as random data. An off-by-one in the chain insertion point would shift the replayed stream by a cycle. A miscounted frame length would either clip the last chained bit or leak stale shift-register contents after it.

Frame sync is pulled again in the middle of a frame, to catch a design that ignores the restart or that keeps the old selects. Selects, chain enable and results are also changed during frames, to expose a design that reads them live instead of latching them at frame start.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

  localparam int unsigned LANES = 3;
  localparam int unsigned CHANS = 6;

  typedef enum logic [1:0] {
    MAP_SPLIT3 = 2'd0,
    MAP_FOLDC  = 2'd1,
    MAP_FOLDB  = 2'd2,
    MAP_SOLO   = 2'd3
  } laneMap_e;

  // strobes from the control to the lane datapath
  typedef struct packed {
    logic           load;
    logic           shift;
    logic           busy;
    logic           chainOn;
    laneMap_e       map;
    logic [LANES-1:0] laneLive;
  } shiftStrb_t;

  function automatic laneMap_e pickMap(input logic selB, input logic selC);
    case ({selB, selC})
      2'b11:   return MAP_SPLIT3;
      2'b10:   return MAP_FOLDC;
      2'b01:   return MAP_FOLDB;
      default: return MAP_SOLO;
    endcase
  endfunction

  // largest number of words a lane can ever hold
  function automatic int unsigned capWords(input int unsigned lane);
    case (lane)
      0:       return 6;
      1:       return 3;
      default: return 2;
    endcase
  endfunction

  function automatic int unsigned wordsOn(input laneMap_e m, input int unsigned lane);
    case (m)
      MAP_SPLIT3: return 2;
      MAP_FOLDC:  return (lane == 2) ? 0 : 3;
      MAP_FOLDB:  return (lane == 0) ? 4 : ((lane == 2) ? 2 : 0);
      default:    return (lane == 0) ? 6 : 0;
    endcase
  endfunction

  // channel index sent in a given slot of a lane
  function automatic int unsigned chanAt(input laneMap_e m, input int unsigned lane,
                                         input int unsigned slot);
    case (m)
      MAP_SPLIT3: return 2 * lane + slot;
      MAP_FOLDC:  return (slot < 2) ? (2 * lane + slot) : (4 + lane);
      MAP_FOLDB:  return (lane == 0) ? slot : (4 + slot);
      default:    return slot;
    endcase
  endfunction

endpackage

// File: rtl/lrs_ctrl.sv
module lrs_ctrl
  import lrs_pkg::*;
#(
  parameter int unsigned CH_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameSyncN,
  input  logic       selB,
  input  logic       selC,
  input  logic       chainEn,
  output shiftStrb_t strb
);

  localparam int unsigned MAX_BITS = 2 * CHANS * CH_W;
  localparam int unsigned CNT_W    = $clog2(MAX_BITS + 1);

  logic             fsPrev;
  logic             busy;
  logic [CNT_W-1:0] cnt;
  laneMap_e         mapQ;
  logic             chainQ;
  logic             startEv;
  logic             lastBit;
  logic [CNT_W-1:0] laneBits [LANES];

  assign startEv = fsPrev & ~frameSyncN;

  for (genvar g = 0; g < LANES; g++) begin : g_len
    assign laneBits[g] = CNT_W'(wordsOn(mapQ, g) * CH_W) << chainQ;
    assign strb.laneLive[g] = busy && (cnt < laneBits[g]);
  end

  // lane A always carries the most bits
  assign lastBit = (cnt == laneBits[0] - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fsPrev <= 1'b0;
      busy   <= 1'b0;
      cnt    <= '0;
      mapQ   <= MAP_SPLIT3;
      chainQ <= 1'b0;
    end else begin
      fsPrev <= frameSyncN;
      if (startEv) begin
        busy   <= 1'b1;
        cnt    <= '0;
        mapQ   <= pickMap(selB, selC);
        chainQ <= chainEn;
      end else if (busy) begin
        if (lastBit) busy <= 1'b0;
        else         cnt  <= cnt + 1'b1;
      end
    end
  end

  assign strb.load    = startEv;
  assign strb.shift   = busy & ~startEv;
  assign strb.busy    = busy;
  assign strb.map     = startEv ? pickMap(selB, selC) : mapQ;
  assign strb.chainOn = startEv ? chainEn : chainQ;

endmodule

// File: rtl/lrs_lanes.sv
module lrs_lanes
  import lrs_pkg::*;
#(
  parameter int unsigned CH_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  shiftStrb_t            strb,
  input  logic [LANES-1:0]      chainIn,
  input  logic [CHANS*CH_W-1:0] resultIn,
  output logic [LANES-1:0]      sdo
);

  logic [CH_W-1:0] chanWord [CHANS];

  for (genvar c = 0; c < CHANS; c++) begin : g_chan
    assign chanWord[c] = resultIn[c*CH_W +: CH_W];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int unsigned CAP   = capWords(g);
    localparam int unsigned DEPTH = CAP * CH_W;
    localparam int unsigned IDX_W = $clog2(DEPTH);

    logic [DEPTH-1:0] sr;
    logic [DEPTH-1:0] loadVal;
    logic [DEPTH-1:0] shiftVal;
    logic             chainBit;
    int unsigned      tail;

    assign chainBit = strb.chainOn & chainIn[g];

    always_comb begin
      loadVal = '0;
      for (int unsigned s = 0; s < CAP; s++) begin
        if (s < wordsOn(strb.map, g))
          loadVal[DEPTH-1-s*CH_W -: CH_W] = chanWord[3'(chanAt(strb.map, g, s))];
      end
    end

    // upstream bits enter just below the local window
    always_comb begin
      tail     = DEPTH - wordsOn(strb.map, g) * CH_W;
      shiftVal = {sr[DEPTH-2:0], 1'b0};
      if (tail < DEPTH) shiftVal[IDX_W'(tail)] = chainBit;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           sr <= '0;
      else if (strb.load)  sr <= loadVal;
      else if (strb.shift) sr <= shiftVal;
    end

    assign sdo[g] = strb.laneLive[g] & sr[DEPTH-1];
  end

endmodule

// File: rtl/lane_result_shifter.sv
module lane_result_shifter
  import lrs_pkg::*;
#(
  parameter int unsigned CH_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  frameSyncN,
  input  logic                  selB,
  input  logic                  selC,
  input  logic                  chainEn,
  input  logic [2:0]            chainIn,
  input  logic [6*CH_W-1:0]     resultIn,
  output logic [2:0]            sdo
);

  shiftStrb_t strb;

  lrs_ctrl #(.CH_W(CH_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .frameSyncN(frameSyncN),
    .selB      (selB),
    .selC      (selC),
    .chainEn   (chainEn),
    .strb      (strb)
  );

  lrs_lanes #(.CH_W(CH_W)) u_lanes (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .chainIn (chainIn),
    .resultIn(resultIn),
    .sdo     (sdo)
  );

endmodule

// File: rtl/lrs_chk.sv
module lrs_chk
  import lrs_pkg::*;
#(
  parameter int unsigned CH_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              selB,
  input logic              selC,
  input logic [6*CH_W-1:0] resultIn,
  input logic [2:0]        sdo,
  input shiftStrb_t        strb
);

  localparam int unsigned MAX_BITS = 2 * CHANS * CH_W;
  localparam int unsigned SC_W     = $clog2(MAX_BITS + 2);

  logic [SC_W-1:0] sinceLoad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         sinceLoad <= SC_W'(MAX_BITS);
    else if (strb.load)                sinceLoad <= '0;
    else if (sinceLoad < SC_W'(MAX_BITS)) sinceLoad <= sinceLoad + 1'b1;
  end

  // R2
  first_bit_a0_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (sdo[0] == $past(resultIn[CH_W-1])));

  // R4
  lane_c_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !selC) |=> !sdo[2]);

  // R6
  lane_b_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !selB) |=> !sdo[1]);

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.busy |-> (sdo == 3'b000));

  // R8
  frame_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceLoad >= SC_W'(MAX_BITS)) |-> (sdo == 3'b000));

  // R10
  map_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.busy && !strb.load) |-> $stable(strb.map));

endmodule

bind lane_result_shifter lrs_chk #(.CH_W(CH_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .selB    (selB),
  .selC    (selC),
  .resultIn(resultIn),
  .sdo     (sdo),
  .strb    (strb)
);

// File: tb/sim_lane_result_shifter.sv
module sim_lane_result_shifter;

  localparam int W = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          frameSyncN = 1'b0;
  logic          selB = 1'b1;
  logic          selC = 1'b1;
  logic          chainEn = 1'b0;
  logic [2:0]    chainIn = 3'b000;
  logic [6*W-1:0] resultIn = '0;
  logic [2:0]    sdo;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state
  bit mFsPrev = 0;
  bit mActive = 0;
  bit mChain = 0;
  int mCnt = 0;
  int mTot [3];
  int mLocal [3];
  bit mQ [3][$];

  always #5 clk = ~clk;

  lane_result_shifter #(.CH_W(W)) u0 (
    .clk(clk), .rstN(rstN), .frameSyncN(frameSyncN), .selB(selB), .selC(selC),
    .chainEn(chainEn), .chainIn(chainIn), .resultIn(resultIn), .sdo(sdo)
  );

  task automatic loadLanes();
    int chs [3][$];
    for (int l = 0; l < 3; l++) begin
      chs[l] = {};
      mQ[l] = {};
    end
    // channel order per lane, taken from the requirements
    if (selB && selC) begin
      chs[0] = {0, 1}; chs[1] = {2, 3}; chs[2] = {4, 5};
    end else if (selB) begin
      chs[0] = {0, 1, 4}; chs[1] = {2, 3, 5};
    end else if (selC) begin
      chs[0] = {0, 1, 2, 3}; chs[2] = {4, 5};
    end else begin
      chs[0] = {0, 1, 2, 3, 4, 5};
    end
    for (int l = 0; l < 3; l++) begin
      foreach (chs[l][k])
        for (int b = W - 1; b >= 0; b--) mQ[l].push_back(resultIn[chs[l][k]*W + b]);
      mLocal[l] = mQ[l].size();
      mTot[l] = chainEn ? 2 * mLocal[l] : mLocal[l];
    end
    mChain = chainEn;
  endtask

  task automatic modelEdge();
    if (mFsPrev && !frameSyncN) begin
      loadLanes();
      mActive = 1;
      mCnt = 0;
    end else if (mActive) begin
      for (int l = 0; l < 3; l++) begin
        if (mQ[l].size() > 0) void'(mQ[l].pop_front());
        if (mChain && mLocal[l] > 0) mQ[l].push_back(chainIn[l]);
      end
      mCnt++;
      if (mCnt >= mTot[0]) mActive = 0;
    end
    mFsPrev = frameSyncN;
  endtask

  task automatic step(string req);
    modelEdge();
    @(posedge clk);
    @(negedge clk);
    for (int l = 0; l < 3; l++) begin
      bit e;
      e = (mActive && mCnt < mTot[l] && mQ[l].size() > 0) ? mQ[l][0] : 1'b0;
      checks++;
      if (sdo[l] !== e) begin
        failures++;
        $display("FAIL %s lane%0d bit%0d: actual=%b expected=%b", req, l, mCnt, sdo[l], e);
      end
    end
  endtask

  task automatic randResults();
    for (int c = 0; c < 6; c++) resultIn[c*W +: W] = W'($urandom);
  endtask

  task automatic frame(bit sb, bit sc, bit ce, int n, bit disturb, string req);
    randResults();
    selB = sb; selC = sc; chainEn = ce;
    frameSyncN = 1'b1;
    step(req);
    frameSyncN = 1'b0;
    for (int i = 0; i < n; i++) begin
      step(req);
      chainIn = 3'($urandom);
      randResults();               // R10: new results must not leak in
      if (disturb && i == 5) begin
        selB = ~selB; selC = ~selC; chainEn = ~chainEn;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (sdo !== 3'b000) begin
      failures++;
      $display("FAIL R8 reset: actual=%b expected=000", sdo);
    end
    rstN = 1'b1;
    // R1: low frame sync with no preceding high must not start a frame
    for (int i = 0; i < 4; i++) step("R1 R8");

    frame(1, 1, 0, 40, 0, "R1 R2 R3");
    frame(1, 0, 0, 56, 0, "R2 R4");
    frame(0, 0, 0, 105, 0, "R2 R5");
    frame(0, 1, 0, 70, 0, "R2 R6");
    frame(1, 1, 1, 70, 0, "R7 R3");
    frame(1, 0, 1, 100, 0, "R7 R4");
    frame(0, 1, 1, 135, 0, "R7 R6");
    frame(0, 0, 1, 200, 0, "R7 R5 R8");
    frame(1, 1, 0, 45, 1, "R10");
    frame(0, 0, 1, 60, 1, "R10");
    // R9: restart in the middle of a frame with new settings
    frame(1, 1, 1, 20, 0, "R9");
    frame(1, 0, 0, 60, 0, "R9");
    frame(0, 1, 0, 12, 0, "R9");
    frame(1, 1, 0, 40, 0, "R9 R8");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule